// File: doc/BRIEF.md
# Lock-step handshake join

This block joins several independent valid/ready streams into one stream. It has one valid and one ready. The output word is all the channel words placed side by side. A beat moves only when every input channel offers data and the consumer accepts it in the same cycle. At that point every input channel completes its handshake together, so the branches never drift apart by even one item.

The ready returned to each branch is not a plain copy of the downstream ready. It is also held low unless every other branch is valid. A branch therefore cannot hand over its item while a sibling still has nothing to offer. The block holds no state and has no clock. The producers and the consumer around it must present registered valid and ready signals, for example from FIFOs, or the combinational path through the block can close a loop. Nested groupings are handled by flattening them into a single list of channels before the join.

Top module: `ls_join`

## Requirements
- R1: `out_valid` is high exactly when every bit of `in_valid` is high.
- R2: `in_ready[i]` is high exactly when `out_ready` is high and every `in_valid[j]` with j different from i is high.
- R3: An input handshake on channel i (`in_valid[i]` and `in_ready[i]` both high) occurs only in a cycle that also has an output handshake (`out_valid` and `out_ready` both high). Every output handshake is accompanied by a handshake on all input channels.
- R4: `out_data` carries channel i's word unchanged in bits `[i*WIDTH +: WIDTH]`, so channel 0 occupies the least significant bits.
- R5: While `out_ready` is low, every bit of `in_ready` is low, whatever the valids are.
- R6: The ready a channel receives does not depend on its own valid. A channel whose own valid is low still sees `in_ready` high when all the others are valid and `out_ready` is high.
- R7: A single valid channel among invalid siblings never completes a handshake, even with `out_ready` high.
- R8: With `NCH` equal to 1 the block is a wire: `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_data` equals `in_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | NCH | Per-channel offer of data |
| in_ready | output | NCH | Per-channel acceptance, gated by sibling validity |
| in_data | input | NCH*WIDTH | Channel words, channel 0 in the lowest bits |
| out_valid | output | 1 | All channels hold data |
| out_ready | input | 1 | Consumer accepts the joined word |
| out_data | output | NCH*WIDTH | Joined word |

## Verification
Several valid patterns are applied directly. All channels idle and all channels valid establish the two extremes. A single valid channel separates a correct join from one that lets a lone branch advance. All-but-one valid, with the missing channel stepped through each position, shows whether a channel's ready wrongly depends on its own valid or ignores a sibling. These are repeated with downstream ready both low and high, which tells the ready gating apart from a plain copy of `out_ready`. Random valids, random ready and random data then run every cycle against a behavioural model. Handshakes per channel are tallied against output handshakes to show that all branches move the same number of times. A one-channel instance confirms the wire case.

// File: rtl/ls_join_pkg.sv
package ls_join_pkg;

  // Lowest bit index of a channel's word inside the joined bus.
  function automatic int lane_base(input int ch, input int width);
    return ch * width;
  endfunction

  // Width of the joined bus for a given channel count and word width.
  function automatic int joined_width(input int nch, input int width);
    return nch * width;
  endfunction

endpackage

// File: rtl/ls_valid_tree.sv
// Computes the AND of all valids and, for each channel, the AND of every
// other channel's valid, using one prefix chain and one suffix chain.
module ls_valid_tree #(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0] vld,
  output logic           all_vld,
  output logic [NCH-1:0] others_vld
);
  logic [NCH:0] pre;
  logic [NCH:0] suf;

  assign pre[0]   = 1'b1;
  assign suf[NCH] = 1'b1;

  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign pre[i+1] = pre[i] & vld[i];
    assign suf[i]   = suf[i+1] & vld[i];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_others
    assign others_vld[i] = pre[i] & suf[i+1];
  end

  assign all_vld = pre[NCH];
endmodule

// File: rtl/ls_ready_fan.sv
// Returns downstream ready to each branch only when its siblings are valid.
module ls_ready_fan #(
  parameter int NCH = 3
) (
  input  logic           dn_rdy,
  input  logic [NCH-1:0] others_vld,
  output logic [NCH-1:0] up_rdy
);
  for (genvar i = 0; i < NCH; i++) begin : g_gate
    assign up_rdy[i] = dn_rdy & others_vld[i];
  end
endmodule

// File: rtl/ls_data_pack.sv
// Places each channel word in its lane of the joined bus.
module ls_data_pack
  import ls_join_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int WIDTH = 8,
  localparam int BUSW = NCH * WIDTH
) (
  input  logic [BUSW-1:0] lanes_in,
  output logic [BUSW-1:0] joined
);
  for (genvar i = 0; i < NCH; i++) begin : g_lane
    localparam int LO = lane_base(i, WIDTH);
    assign joined[LO +: WIDTH] = lanes_in[LO +: WIDTH];
  end
endmodule

// File: rtl/ls_join.sv
module ls_join
  import ls_join_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int WIDTH = 8,
  localparam int BUSW = joined_width(NCH, WIDTH)
) (
  input  logic [NCH-1:0]  in_valid,
  output logic [NCH-1:0]  in_ready,
  input  logic [BUSW-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [BUSW-1:0] out_data
);
  // Named events for the checker.
  logic           xfer;
  logic [NCH-1:0] chan_xfer;

  if (NCH == 1) begin : g_wire
    assign out_valid = in_valid[0];
    assign in_ready  = out_ready;
    assign out_data  = in_data;
  end else begin : g_join
    logic           all_vld;
    logic [NCH-1:0] others_vld;

    ls_valid_tree #(.NCH(NCH)) u_tree (
      .vld        (in_valid),
      .all_vld    (all_vld),
      .others_vld (others_vld)
    );

    ls_ready_fan #(.NCH(NCH)) u_fan (
      .dn_rdy     (out_ready),
      .others_vld (others_vld),
      .up_rdy     (in_ready)
    );

    ls_data_pack #(.NCH(NCH), .WIDTH(WIDTH)) u_pack (
      .lanes_in (in_data),
      .joined   (out_data)
    );

    assign out_valid = all_vld;
  end

  assign xfer      = out_valid & out_ready;
  assign chan_xfer = in_valid & in_ready;
endmodule

// File: rtl/ls_join_chk.sv
module ls_join_chk #(
  parameter int NCH   = 3,
  parameter int WIDTH = 8,
  localparam int BUSW = NCH * WIDTH
) (
  input logic [NCH-1:0]  in_valid,
  input logic [NCH-1:0]  in_ready,
  input logic [BUSW-1:0] in_data,
  input logic            out_valid,
  input logic            out_ready,
  input logic [BUSW-1:0] out_data,
  input logic            xfer,
  input logic [NCH-1:0]  chan_xfer
);
  always_comb begin
    AST_VALID_NEEDS_ALL: assert (!out_valid || (in_valid == {NCH{1'b1}})) else $error("out_valid without all valids"); // R1
    AST_ALL_MOVE: assert (!xfer || (chan_xfer == {NCH{1'b1}})) else $error("output moved without all inputs"); // R3
    AST_STALL_ALL: assert (out_ready || (in_ready == '0)) else $error("ready leaked while downstream stalled"); // R5
    for (int i = 0; i < NCH; i++) begin
      AST_NO_LONE_MOVE: assert (!chan_xfer[i] || xfer) else $error("channel %0d moved alone", i); // R3
      AST_LANE_KEPT: assert (out_data[i*WIDTH +: WIDTH] == in_data[i*WIDTH +: WIDTH]) else $error("lane %0d altered", i); // R4
    end
  end
endmodule

bind ls_join ls_join_chk #(.NCH(NCH), .WIDTH(WIDTH)) u_chk (
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .xfer      (xfer),
  .chan_xfer (chan_xfer)
);

// File: tb/tb_ls_join.sv
`timescale 1ns/1ps
module tb_ls_join;
  localparam int NCH   = 3;
  localparam int WIDTH = 8;
  localparam int BUSW  = NCH * WIDTH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NCH-1:0]  in_valid  = '0;
  logic [NCH-1:0]  in_ready;
  logic [BUSW-1:0] in_data   = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [BUSW-1:0] out_data;

  logic             s_valid = 1'b0;
  logic [0:0]       s_ready;
  logic [WIDTH-1:0] s_data  = '0;
  logic             s_ovalid;
  logic             s_oready = 1'b0;
  logic [WIDTH-1:0] s_odata;

  ls_join #(.NCH(NCH), .WIDTH(WIDTH)) dut (
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  ls_join #(.NCH(1), .WIDTH(WIDTH)) dut_single (
    .in_valid (s_valid), .in_ready (s_ready), .in_data (s_data),
    .out_valid(s_ovalid), .out_ready(s_oready), .out_data(s_odata)
  );

  int total = 0;
  int bad = 0;
  int in_moves [NCH];
  int out_moves = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference for the multi-channel instance.
  task automatic compare_main();
    int nvalid;
    bit exp_ov;
    bit exp_rdy;
    bit any_in;
    nvalid = 0;
    for (int i = 0; i < NCH; i++) if (in_valid[i]) nvalid++;
    exp_ov = (nvalid == NCH);
    chk("R1", "out_valid", out_valid, exp_ov);
    for (int i = 0; i < NCH; i++) begin
      int others;
      others = nvalid - (in_valid[i] ? 1 : 0);
      exp_rdy = out_ready && (others == NCH - 1);
      chk("R2", $sformatf("in_ready[%0d]", i), in_ready[i], exp_rdy);
      if (!out_ready) chk("R5", $sformatf("stalled in_ready[%0d]", i), in_ready[i], 0);
      if (!in_valid[i] && others == NCH - 1 && out_ready)
        chk("R6", $sformatf("own-invalid in_ready[%0d]", i), in_ready[i], 1);
      chk("R4", $sformatf("lane %0d", i), out_data[i*WIDTH +: WIDTH], in_data[i*WIDTH +: WIDTH]);
    end
    any_in = 0;
    for (int i = 0; i < NCH; i++) begin
      if (in_valid[i] && in_ready[i]) begin
        in_moves[i]++;
        any_in = 1;
      end
    end
    if (out_valid && out_ready) out_moves++;
    if (any_in) chk("R3", "input move needs output move", out_valid && out_ready, 1);
  endtask

  task automatic compare_single();
    chk("R8", "single out_valid", s_ovalid, s_valid);
    chk("R8", "single in_ready", s_ready[0], s_oready);
    chk("R8", "single out_data", s_odata, s_data);
  endtask

  task automatic apply(input logic [NCH-1:0] v, input logic r, input logic [BUSW-1:0] d);
    @(posedge clk);
    #1;
    in_valid  = v;
    out_ready = r;
    in_data   = d;
    s_valid   = v[0];
    s_oready  = r;
    s_data    = d[WIDTH-1:0];
    #2;
    compare_main();
    compare_single();
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) in_moves[i] = 0;
    repeat (3) @(posedge clk);
    #3;
    // Reset state: all idle.
    chk("R1", "idle out_valid", out_valid, 0);
    chk("R5", "idle in_ready", in_ready, 0);
    rst_n = 1'b1;

    apply('0, 1'b1, 24'h112233);
    apply('1, 1'b0, 24'hA5C3E1);
    apply('1, 1'b1, 24'h0F1E2D);
    chk("R3", "all channels moved", in_ready & in_valid, 3'b111);
    for (int k = 0; k < NCH; k++) begin
      logic [NCH-1:0] lone;
      lone = '0;
      lone[k] = 1'b1;
      apply(lone, 1'b1, 24'h445566);
      chk("R7", $sformatf("lone channel %0d", k), in_ready[k], 0);
    end
    for (int k = 0; k < NCH; k++) begin
      logic [NCH-1:0] miss;
      miss = '1;
      miss[k] = 1'b0;
      apply(miss, 1'b1, 24'h778899);
      chk("R6", $sformatf("missing channel %0d ready", k), in_ready[k], 1);
      apply(miss, 1'b0, 24'h778899);
    end

    for (int n = 0; n < 400; n++) begin
      logic [NCH-1:0] v;
      for (int i = 0; i < NCH; i++) v[i] = ($urandom % 4) != 0;
      apply(v, 1'($urandom % 2), BUSW'($urandom));
    end

    for (int i = 0; i < NCH; i++)
      chk("R3", $sformatf("moves channel %0d vs output", i), in_moves[i], out_moves);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule